// File: doc/BRIEF.md
# Shift-and-Add Multiplier Sequencer

This block is the control unit for a serial multiplier. The datapath holds a partial product and a multiplier that shifts right. The block stays idle until it sees a start request. It then sends a load command and enters a loop that runs once for each multiplier bit. Each pass has a test cycle that looks at the multiplier's current low bit. An optional add cycle follows when that bit is set, and then one shift cycle. After the last shift the block returns to idle. The datapath registers and the adder belong to the surrounding design. A registered counter inside the block tracks how many shifts have been made.

The state register starts in the idle state, so the block works whether or not the reset is ever pulsed. The next-state logic sends any undefined state code back to idle. All command outputs are decoded from the current state alone.

Top module: `mulseq_ctrl`

## Requirements
- R1: With reset never asserted, the block comes up with `idle_o` = 1 and `load_o`, `add_o` and `shift_o` all 0, and it then completes a full multiply.
- R2: While idle with `start_i` low, the block stays idle and issues no command.
- R3: When `start_i` is high in the idle state, `load_o` is 1 in the next cycle only. The cycle after that is a test cycle, in which all four outputs are 0.
- R4: In any cycle at most one of `idle_o`, `load_o`, `add_o` and `shift_o` is 1.
- R5: After a test cycle with `lsb_i` = 1, the next cycle has `add_o` = 1 and the cycle after that has `shift_o` = 1. After a test cycle with `lsb_i` = 0, the next cycle has `shift_o` = 1.
- R6: One operation issues exactly OPERAND_W shift commands and then returns to idle. From the load cycle to the last shift it lasts 1 + 2*OPERAND_W + (number of set multiplier bits) cycles.
- R7: A high `rst` at a clock edge forces the idle state at that edge, from any state. The next start runs a full-length sequence with the shift count restarted.
- R8: The next-state function maps every state code outside the five defined ones (codes 5, 6 and 7 of the 3-bit encoding) to idle (code 0), whatever the inputs.
- R9: Commands applied to a shift-and-add datapath (add the multiplicand into the upper half, then shift right by one) leave the exact product of the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a multiply |
| lsb_i | input | 1 | Current low bit of the multiplier register |
| idle_o | output | 1 | High while waiting for a start request |
| load_o | output | 1 | Load the operands and clear the partial product |
| add_o | output | 1 | Add the multiplicand into the partial product |
| shift_o | output | 1 | Shift the partial product and multiplier right |

## Verification
The bench runs a small datapath model driven only by the block's commands. It checks the final product against the arithmetic result, so a wrong loop bound shows up as a product off by a power of two. It also checks that each add is taken exactly when the tested bit is set, since a skipped or extra add gives a wrong sum. Multipliers 0x00 and 0xFF test the case with no adds and the case with an add in every pass. The first multiply runs with reset never asserted; an uninitialised state register would never leave an unknown state. A reset in mid-run followed by a fresh multiply catches a shift counter that is not cleared again on load.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

  typedef enum logic [2:0] {
    MS_IDLE  = 3'd0,
    MS_INIT  = 3'd1,
    MS_TEST  = 3'd2,
    MS_ADD   = 3'd3,
    MS_SHIFT = 3'd4
  } ms_state_e;

  // Next-state rule; any undefined code drops back to idle
  function automatic ms_state_e ms_next(input logic [2:0] cur, input logic start,
                                        input logic lsb, input logic last);
    ms_state_e nxt;
    case (cur)
      MS_IDLE:  nxt = start ? MS_INIT : MS_IDLE;
      MS_INIT:  nxt = MS_TEST;
      MS_TEST:  nxt = lsb ? MS_ADD : MS_SHIFT;
      MS_ADD:   nxt = MS_SHIFT;
      MS_SHIFT: nxt = last ? MS_IDLE : MS_TEST;
      default:  nxt = MS_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/mulseq_next.sv
module mulseq_next
  import mulseq_pkg::*;
(
  input  ms_state_e state_i,
  input  logic      start_i,
  input  logic      lsb_i,
  input  logic      last_i,
  output ms_state_e next_o
);

  always_comb next_o = ms_next(state_i, start_i, lsb_i, last_i);

endmodule

// File: rtl/mulseq_shcnt.sv
module mulseq_shcnt #(
  parameter int unsigned OPERAND_W = 8,
  localparam int unsigned CNT_W    = $clog2(OPERAND_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OPERAND_W - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(OPERAND_W);

  function automatic logic at_last(input logic [CNT_W-1:0] c);
    return c == LAST_CNT;
  endfunction

  logic [CNT_W-1:0] cnt_q = '0;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = at_last(cnt_q);

  // R6: the count never runs past the operand width
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= MAX_CNT);

  // R6: a clear always lands on zero
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q == '0);

endmodule

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
  import mulseq_pkg::*;
#(
  parameter int unsigned OPERAND_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic lsb_i,
  output logic idle_o,
  output logic load_o,
  output logic add_o,
  output logic shift_o
);

  localparam int unsigned CNT_W = $clog2(OPERAND_W + 1);

  ms_state_e        state_q = MS_IDLE;
  ms_state_e        state_d;
  logic [CNT_W-1:0] shift_cnt;
  logic             last_shift;
  logic             in_test;

  mulseq_next u_next (
    .state_i (state_q),
    .start_i (start_i),
    .lsb_i   (lsb_i),
    .last_i  (last_shift),
    .next_o  (state_d)
  );

  mulseq_shcnt #(.OPERAND_W(OPERAND_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (load_o),
    .inc_i  (shift_o),
    .cnt_o  (shift_cnt),
    .last_o (last_shift)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= MS_IDLE;
    else     state_q <= state_d;
  end

  assign idle_o  = (state_q == MS_IDLE);
  assign load_o  = (state_q == MS_INIT);
  assign add_o   = (state_q == MS_ADD);
  assign shift_o = (state_q == MS_SHIFT);
  assign in_test = (state_q == MS_TEST);

  // R2
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    idle_o && !start_i |=> idle_o);
  // R3
  p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
    idle_o && start_i |=> load_o);
  p_load_test_r3: assert property (@(posedge clk) disable iff (rst)
    load_o |=> in_test);
  // R4
  p_one_cmd_r4: assert property (@(posedge clk)
    $onehot0({idle_o, load_o, add_o, shift_o, in_test}));
  // R5
  p_test_add_r5: assert property (@(posedge clk) disable iff (rst)
    in_test && lsb_i |=> add_o);
  p_test_shift_r5: assert property (@(posedge clk) disable iff (rst)
    in_test && !lsb_i |=> shift_o);
  p_add_shift_r5: assert property (@(posedge clk) disable iff (rst)
    add_o |=> shift_o);
  // R6
  p_last_exit_r6: assert property (@(posedge clk) disable iff (rst)
    shift_o && last_shift |=> idle_o);
  // R7
  p_reset_idle_r7: assert property (@(posedge clk)
    rst |=> idle_o);

endmodule

// File: tb/mulseq_ctrl_bench.sv
`timescale 1ns/1ps
module mulseq_ctrl_bench;
  import mulseq_pkg::*;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic start_i = 1'b0;
  logic lsb_i = 1'b0;
  logic idle_o, load_o, add_o, shift_o;

  int checks = 0;
  int fails  = 0;
  int cycles_run = 0;
  logic [16:0] p;

  always #5 clk = ~clk;

  mulseq_ctrl #(.OPERAND_W(W)) u_mulseq_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .lsb_i(lsb_i),
    .idle_o(idle_o), .load_o(load_o), .add_o(add_o), .shift_o(shift_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int exp_len(input logic [7:0] b);
    return 1 + 2 * W + popc(b);
  endfunction

  function automatic int outs();
    return int'({idle_o, load_o, add_o, shift_o});
  endfunction

  // one multiply through the datapath model
  task automatic run_mul(input logic [7:0] a, input logic [7:0] b, input string req);
    int len = 0, adds = 0, shifts = 0, bad = 0, bad5 = 0;
    logic was_load = 1'b0, was_test = 1'b0, t_lsb = 1'b0;
    @(negedge clk);
    chk(req, "idle before start", int'(idle_o), 1);
    start_i = 1'b1;
    @(negedge clk);
    chk("R3", "load after start", outs(), 4'b0100);
    start_i = 1'b0;
    p = {9'd0, b};
    lsb_i = p[0];
    len = 1;
    was_load = 1'b1;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (idle_o) break;
      len++;
      if ($countones({load_o, add_o, shift_o}) > 1) bad++;
      if (was_load && outs() != 0) bad++;
      if (was_test && t_lsb && !add_o) bad5++;
      if (was_test && !t_lsb && !shift_o) bad5++;
      was_load = 1'b0;
      was_test = (outs() == 0);
      t_lsb = lsb_i;
      if (add_o) begin
        adds++;
        p[16:8] = {1'b0, p[15:8]} + {1'b0, a};
      end
      if (shift_o) begin
        shifts++;
        p = p >> 1;
      end
      lsb_i = p[0];
    end
    chk("R4", "overlapping or wrong outputs", bad, 0);
    chk("R5", "branch after test", bad5, 0);
    chk("R5", "add count", adds, popc(b));
    chk("R6", "shift count", shifts, W);
    chk("R6", "sequence length", len, exp_len(b));
    chk("R9", "product", int'(p[15:0]), int'(a) * int'(b));
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s;
    s = int'($urandom(32'h5eed_1234));
    // R1: no reset at all
    @(negedge clk);
    chk("R1", "power-up outputs", outs(), 4'b1000);
    // R2: idle holds
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2", "idle hold", outs(), 4'b1000);
    end
    run_mul(8'd13, 8'd11, "R1");
    // corners
    run_mul(8'd200, 8'h00, "R9");
    run_mul(8'hFF, 8'hFF, "R9");
    run_mul(8'h01, 8'h80, "R9");
    // R7: reset mid-run
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 5; i++) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R7", "reset to idle", outs(), 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk("R7", "idle after reset", outs(), 4'b1000);
    run_mul(8'd77, 8'd201, "R7");
    // R8: undefined codes recover
    for (int c = 5; c < 8; c++)
      for (int v = 0; v < 8; v++)
        chk("R8", "undefined code next", int'(ms_next(3'(c), v[0], v[1], v[2])), int'(MS_IDLE));
    // random
    for (int n = 0; n < 25; n++) run_mul(8'($urandom), 8'($urandom), "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule